// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects eight peripheral interrupt lines and presents them to a processor as one maskable request wire. Each line is edge-sensitive. A rising edge is latched into a pending register and stays there until the processor takes it, even if the line drops again. Software can hold back any line through a mask register. Among the unmasked pending lines the lowest-numbered one always wins. When the winner may be delivered, the controller raises its request output.

When the processor pulses the acknowledge input, the winning level is moved from pending to in-service in a single cycle. An 8-bit vector is then returned: a software-set base with its three low bits zero, plus the level number. While a level is in service, requests of equal or lesser urgency are held back, but a more urgent one still raises the request, so handlers nest. A handler finishes by writing the end-of-service byte 20h to the command address. That write retires the most urgent level in service.

Top module: `nic_ctrl`

## Requirements
- R1: After reset, intr is 0, vector is 0, the mask register reads FFh (all levels blocked) and the in-service register reads 00h.
- R2: A 0-to-1 transition on irq_in[i] sets pending bit i, which stays set after the line falls until acknowledged; a line held high after its acknowledge does not raise a new request.
- R3: A pending level whose mask bit is 1 is not delivered; it stays pending and is delivered once its mask bit is written to 0 (mask lives at cfg_addr 1, bit i controls level i).
- R4: When several unmasked levels are pending, the one with the lowest number is delivered first.
- R5: intr rises on the second clock edge after the input edge (one edge to latch, one to decide) and is 0 on the edge where inta is sampled high.
- R6: On the edge where inta is high and a request is deliverable, vector becomes base plus the winning level number, that level's pending bit clears and its in-service bit sets.
- R7: While level n is in service, pending levels numbered n or higher keep intr at 0, while a pending level numbered below n raises intr.
- R8: Writing 20h to cfg_addr 0 clears the lowest-numbered set in-service bit; it changes nothing when no bit is set, and any other byte written to cfg_addr 0 has no effect.
- R9: Writing cfg_addr 2 sets the vector base, with its three low bits forced to 0.
- R10: cfg_rdata shows, one edge after cfg_addr is presented, the pending register (addr 0), mask (addr 1), base (addr 2) or in-service register (addr 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Edge-sensitive request lines, level 0 most urgent |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 command, 1 mask, 2 base, 3 in-service (read) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered read data |
| inta | input | 1 | Processor acknowledge, one-cycle pulse |
| intr | output | 1 | Request to the processor |
| vector | output | 8 | Vector of the last acknowledged level |

## Verification
A pending bit appears on the edge after an input edge, and intr follows one edge later. So the bench raises a line at a falling edge and looks at intr two rising edges on. Vector, pending clear and intr drop all land on the same edge that samples inta, and are read at the falling edge right after it. A mask or command write takes effect on its own edge, and intr reflects it one edge later. Read data trails the address by one edge. Every check is made at a falling edge after exactly the number of rising edges that its result needs.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int NIC_LEVELS = 8;
  localparam int NIC_DATA_W = 8;
  localparam int NIC_ADDR_W = 2;
  localparam logic [NIC_DATA_W-1:0] NIC_EOI_CODE = 8'h20;

  typedef enum logic [NIC_ADDR_W-1:0] {
    NIC_A_CMD  = 2'd0,
    NIC_A_MASK = 2'd1,
    NIC_A_BASE = 2'd2,
    NIC_A_ISR  = 2'd3
  } nic_addr_e;
endpackage

// File: rtl/nic_prio_pick.sv
module nic_prio_pick #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          valid,
  output logic [LW-1:0] idx,
  output logic [N-1:0]  onehot
);
  logic [N-1:0] below;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      if (g == 0) begin : g_first
        assign below[g] = 1'b0;
      end else begin : g_rest
        assign below[g] = below[g-1] | vec[g-1];
      end
      assign onehot[g] = vec[g] & ~below[g];
    end
  endgenerate

  assign valid = |vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = LW'(i);
    end
  end
endmodule

// File: rtl/nic_req_latch.sv
module nic_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] req
);
  logic [N-1:0] irq_q;
  logic [N-1:0] rise;

  assign rise = irq_in & ~irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= '0;
      req   <= '0;
    end else begin
      irq_q <= irq_in;
      req   <= (req & ~clr) | rise;
    end
  end

  // R2: a pending bit never disappears unless it was cleared by an acknowledge
  a_r2_req_holds: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(req) & ~$past(clr)) & ~req) == '0));
endmodule

// File: rtl/nic_isr_track.sv
module nic_isr_track #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [N-1:0]  set_onehot,
  input  logic          eoi,
  output logic [N-1:0]  isr,
  output logic          top_valid,
  output logic [LW-1:0] top_idx
);
  logic [N-1:0] top_onehot;
  logic [N-1:0] clr_mask;
  logic [N-1:0] set_mask;

  nic_prio_pick #(.N(N)) u_top (
    .vec    (isr),
    .valid  (top_valid),
    .idx    (top_idx),
    .onehot (top_onehot)
  );

  assign clr_mask = eoi    ? top_onehot : '0;
  assign set_mask = set_en ? set_onehot : '0;

  always_ff @(posedge clk) begin
    if (rst) isr <= '0;
    else     isr <= (isr & ~clr_mask) | set_mask;
  end

  // R8: end-of-service retires exactly one level when any is in service
  a_r8_eoi_retires_one: assert property (@(posedge clk) disable iff (rst)
    (eoi && !set_en && top_valid) |=> ($countones(isr) == $past($countones(isr)) - 1));

  // R8: end-of-service with nothing in service leaves the register alone
  a_r8_eoi_empty: assert property (@(posedge clk) disable iff (rst)
    (eoi && !set_en && !top_valid) |=> (isr == '0));

  // R6: an acknowledge adds a level that was not yet in service
  a_r6_ack_adds: assert property (@(posedge clk) disable iff (rst)
    (set_en && !eoi) |=> ($countones(isr) == $past($countones(isr)) + 1));
endmodule

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
  import nic_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int AW = 2,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  isr,
  output logic [N-1:0]  mask,
  output logic [DW-1:0] base,
  output logic          eoi,
  output logic [DW-1:0] cfg_rdata
);
  localparam logic [N-1:0]  MASK_RST = '1;
  localparam logic [DW-1:0] BASE_KEEP = {{(DW-LW){1'b1}}, {LW{1'b0}}};

  assign eoi = cfg_we && (cfg_addr == AW'(NIC_A_CMD)) && (cfg_wdata == NIC_EOI_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask      <= MASK_RST;
      base      <= '0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_we && cfg_addr == AW'(NIC_A_MASK)) mask <= cfg_wdata[N-1:0];
      if (cfg_we && cfg_addr == AW'(NIC_A_BASE)) base <= cfg_wdata & BASE_KEEP;
      case (cfg_addr)
        AW'(NIC_A_CMD):  cfg_rdata <= DW'(req);
        AW'(NIC_A_MASK): cfg_rdata <= DW'(mask);
        AW'(NIC_A_BASE): cfg_rdata <= base;
        default:         cfg_rdata <= DW'(isr);
      endcase
    end
  end
endmodule

// File: rtl/nic_ctrl.sv
module nic_ctrl
  import nic_pkg::*;
#(
  parameter int N  = NIC_LEVELS,
  parameter int DW = NIC_DATA_W,
  parameter int AW = NIC_ADDR_W,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_in,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          inta,
  output logic          intr,
  output logic [DW-1:0] vector
);
  logic [N-1:0]  req, mask, isr, cand, cand_onehot, req_clr;
  logic [DW-1:0] base;
  logic          eoi, cand_valid, isr_valid, fwd, ack;
  logic [LW-1:0] cand_idx, isr_idx;

  nic_cfg_regs #(.N(N), .DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .req       (req),
    .isr       (isr),
    .mask      (mask),
    .base      (base),
    .eoi       (eoi),
    .cfg_rdata (cfg_rdata)
  );

  nic_req_latch #(.N(N)) u_req (
    .clk    (clk),
    .rst    (rst),
    .irq_in (irq_in),
    .clr    (req_clr),
    .req    (req)
  );

  assign cand = req & ~mask;

  nic_prio_pick #(.N(N)) u_pick (
    .vec    (cand),
    .valid  (cand_valid),
    .idx    (cand_idx),
    .onehot (cand_onehot)
  );

  nic_isr_track #(.N(N)) u_isr (
    .clk        (clk),
    .rst        (rst),
    .set_en     (ack),
    .set_onehot (cand_onehot),
    .eoi        (eoi),
    .isr        (isr),
    .top_valid  (isr_valid),
    .top_idx    (isr_idx)
  );

  assign fwd     = cand_valid && (!isr_valid || (cand_idx < isr_idx));
  assign ack     = inta && fwd;
  assign req_clr = ack ? cand_onehot : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      intr   <= 1'b0;
      vector <= '0;
    end else begin
      intr <= inta ? 1'b0 : fwd;
      if (ack) vector <= base | DW'(cand_idx);
    end
  end

  // R5: the request line drops on the acknowledge edge
  a_r5_intr_drop: assert property (@(posedge clk) disable iff (rst)
    inta |=> !intr);

  // R9: a returned vector carries the programmed base in its upper bits
  a_r9_vec_base: assert property (@(posedge clk) disable iff (rst)
    ack |=> (vector[DW-1:LW] == $past(base[DW-1:LW])));

  // R6: the acknowledged level leaves the pending register
  a_r6_pending_cleared: assert property (@(posedge clk) disable iff (rst)
    ack |=> ((req & $past(cand_onehot)) == '0 || $past(irq_in & cand_onehot) != '0));
endmodule

// File: tb/nic_ctrl_bench.sv
module nic_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       inta = 1'b0;
  logic       intr;
  logic [7:0] vector;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam logic [7:0] BASE = 8'h48;

  // {mask, irq pulse, expected level, expected intr}
  localparam logic [19:0] TBL [10] = '{
    {8'h00, 8'h01, 3'd0, 1'b1},
    {8'h00, 8'h80, 3'd7, 1'b1},
    {8'h00, 8'h28, 3'd3, 1'b1},
    {8'h08, 8'h28, 3'd5, 1'b1},
    {8'h00, 8'h00, 3'd3, 1'b1},
    {8'hFF, 8'h04, 3'd0, 1'b0},
    {8'h00, 8'h00, 3'd2, 1'b1},
    {8'h00, 8'hF0, 3'd4, 1'b1},
    {8'h0F, 8'h11, 3'd4, 1'b1},
    {8'h00, 8'h00, 3'd0, 1'b1}
  };

  nic_ctrl u_nic_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .inta(inta), .intr(intr), .vector(vector)
  );

  always #2 clk = ~clk;

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cfg_addr = a;
    tick();
    d = cfg_rdata;
  endtask

  task automatic pulse(input logic [7:0] p);
    irq_in = irq_in | p;
    tick();
    irq_in = irq_in & ~p;
    tick();
  endtask

  task automatic ack();
    inta = 1'b1;
    tick();
    inta = 1'b0;
  endtask

  task automatic eoi();
    wr(2'd0, 8'h20);
    tick();
  endtask

  task automatic drain();
    for (int k = 0; k < 8; k++) begin
      if (intr) begin
        ack();
        eoi();
      end
    end
  endtask

  initial begin
    logic [7:0] d;
    tick(); tick();
    rst = 1'b0;
    tick();
    check("R1 intr", {7'd0, intr}, 8'h00);
    check("R1 vector", vector, 8'h00);
    rd(2'd1, d); check("R1 R10 mask", d, 8'hFF);
    rd(2'd3, d); check("R1 isr", d, 8'h00);

    wr(2'd2, 8'h4F);
    rd(2'd2, d); check("R9 base low bits zero", d, BASE);

    for (int e = 0; e < 10; e++) begin
      wr(2'd1, TBL[e][19:12]);
      pulse(TBL[e][11:4]);
      check($sformatf("R3 R4 R5 intr entry %0d", e), {7'd0, intr}, {7'd0, TBL[e][0]});
      if (TBL[e][0]) begin
        ack();
        check($sformatf("R4 R6 vector entry %0d", e), vector, BASE | {5'd0, TBL[e][3:1]});
        check($sformatf("R5 intr drop entry %0d", e), {7'd0, intr}, 8'h00);
        eoi();
        drain();
      end
    end
    rd(2'd1, d); check("R3 mask readback", d, 8'h00);

    // R3 masked request visible as pending
    wr(2'd1, 8'h40);
    pulse(8'h40);
    check("R3 masked no intr", {7'd0, intr}, 8'h00);
    rd(2'd0, d); check("R3 R10 pending readback", d, 8'h40);
    wr(2'd1, 8'h00);
    tick();
    check("R3 unmask delivers", {7'd0, intr}, 8'h01);
    ack();
    check("R6 vector 6", vector, BASE | 8'h06);
    rd(2'd0, d); check("R6 pending cleared", d, 8'h00);
    rd(2'd3, d); check("R6 isr set", d, 8'h40);
    eoi();

    // R2 held line does not retrigger
    irq_in[1] = 1'b1;
    tick(); tick();
    check("R2 held line intr", {7'd0, intr}, 8'h01);
    ack();
    check("R2 vector 1", vector, BASE | 8'h01);
    eoi();
    check("R2 no retrigger", {7'd0, intr}, 8'h00);
    rd(2'd0, d); check("R2 pending empty", d, 8'h00);
    irq_in[1] = 1'b0;
    tick();
    pulse(8'h02);
    check("R2 new edge", {7'd0, intr}, 8'h01);
    ack(); eoi();

    // R7 nesting
    pulse(8'h08);
    ack();
    check("R7 vector 3", vector, BASE | 8'h03);
    pulse(8'h20);
    check("R7 lower blocked", {7'd0, intr}, 8'h00);
    pulse(8'h08);
    check("R7 same blocked", {7'd0, intr}, 8'h00);
    wr(2'd0, 8'h60);
    rd(2'd3, d); check("R8 other byte ignored", d, 8'h08);
    pulse(8'h02);
    check("R7 higher preempts", {7'd0, intr}, 8'h01);
    ack();
    check("R7 vector 1", vector, BASE | 8'h01);
    rd(2'd3, d); check("R7 nested isr", d, 8'h0A);
    eoi();
    rd(2'd3, d); check("R8 eoi clears most urgent", d, 8'h08);
    check("R7 still blocked", {7'd0, intr}, 8'h00);
    eoi();
    check("R8 pending released", {7'd0, intr}, 8'h01);
    ack();
    check("R4 vector 3 again", vector, BASE | 8'h03);
    eoi();
    drain();
    rd(2'd3, d); check("R8 isr empty", d, 8'h00);
    eoi();
    rd(2'd3, d); check("R8 eoi on empty", d, 8'h00);
    check("R8 no intr", {7'd0, intr}, 8'h00);

    finish_run();
  end
endmodule